// File: doc/BRIEF.md
# Register Context Loader Engine

The block applies a batch of register writes that software has prepared in memory. Each list entry is 8 bytes: a 32-bit value word at the lower address and a 32-bit target-offset word at the next word. Software describes two lists through configuration registers and then sets an enable bit. The first is a double-buffered list with its own base and count. The second is a single-buffered region, split into a high-priority sublist and a low-priority sublist. The engine fetches each entry with two reads on a request/response memory port. It then presents the pair on a register-write output port, with the value as data and the offset as address.

The low-priority entries follow the last high-priority entry directly, so one base address serves the whole single-buffered region. When the run ends, the enable bit returns to zero by itself. Each region that held entries raises its own completion flag. A failing memory read stops the run. It raises an error flag and records the failing address. Every status flag has a matching interrupt enable, and the interrupt output combines them. Two further flags are set by external sequencing events.

Top module: `ctx_loader`

## Requirements
- R1: After reset every configuration register reads 0, `irq` is 0, and neither `mem_req` nor `wr_valid` is asserted while the enable bit (control register 0x00, bit 0) is 0.
- R2: Each entry at byte address A is fetched as two reads, the value word at A and then the offset word at A+4. It produces one write with `wr_addr` equal to the offset word and `wr_data` equal to the value word.
- R3: Within one run the double-buffered list (base 0x10, count 0x14) is written first, then the high-priority sublist, then the low-priority sublist. The single-buffered region uses base 0x18 and count 0x1C, with the high-priority count in bits [15:0] and the low-priority count in bits [31:16]. The low-priority sublist starts at that base plus 8 times the high-priority count.
- R4: A count of 0 skips its region: it causes no read, no write and no completion flag. A run with all counts 0 ends with no write.
- R5: While a run is in progress the enable bit reads 1. At the end it returns to 0. The control register then shows status bit 17 if the double-buffered list was non-empty, bit 18 if the high-priority sublist was non-empty, and bit 19 if the low-priority sublist was non-empty.
- R6: A read answered with `mem_rerr` ends the run at once. It sets status bit 16, clears enable, issues no further write and stores the failing byte address in register 0x20. A read answered with `mem_berr` does the same, except that it sets status bit 22.
- R7: Writing 1 to the enable bit while a run is in progress has no effect. The base and count registers are sampled when the run starts, so rewriting them during a run changes only later runs.
- R8: Writing 1 to status bit 16+k of the control register clears that flag, and writing 0 leaves it. A one-cycle pulse on `evt_db_pend` sets bit 20, and a pulse on `evt_sb_pend` sets bit 21.
- R9: Control bits 2 to 8 enable the flags at bits 16 to 22, in the same order. `irq` is 1 one cycle after any enabled flag is set, and 0 one cycle after no enabled flag remains.
- R10: While `wr_ready` is 0, an asserted `wr_valid` stays asserted with `wr_addr` and `wr_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response data |
| mem_rerr | input | 1 | Response carries a read error |
| mem_berr | input | 1 | Response carries a bus error |
| wr_valid | output | 1 | Register write valid |
| wr_addr | output | 32 | Register write offset |
| wr_data | output | 32 | Register write value |
| wr_ready | input | 1 | Register write accepted |
| evt_db_pend | input | 1 | External event: double-buffered list pending when the single-buffered list was received |
| evt_sb_pend | input | 1 | External event: single-buffered list pending while the display was active |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a second enable write, together with a rewritten count register, arriving while a run is still going. A run is normally over within a few dozen cycles. The bench holds `wr_ready` low most of the time so that a six-entry run lasts long enough. During that run it rewrites the count and re-arms the engine. It then checks that exactly the originally sampled entries were written, and that the next run uses the new count. Aborts are reached by flagging one chosen read address as faulty. One case places the fault on the offset word of the second entry, and another on the very first read of the single-buffered region.

// File: rtl/ctxl_pkg.sv
package ctxl_pkg;
   typedef enum logic [1:0] {RG_DB = 2'd0, RG_HP = 2'd1, RG_LP = 2'd2} region_e;
   typedef enum logic [1:0] {FE_NONE = 2'd0, FE_READ = 2'd1, FE_BUS = 2'd2} ferr_e;

   localparam int EV_N      = 7;
   localparam int EV_RDERR  = 0;
   localparam int EV_DBDONE = 1;
   localparam int EV_HPDONE = 2;
   localparam int EV_LPDONE = 3;
   localparam int EV_DBPEND = 4;
   localparam int EV_SBPEND = 5;
   localparam int EV_BUSERR = 6;

   localparam int IE_LSB    = 2;
   localparam int STS_LSB   = 16;
   localparam int LPC_LSB   = 16;

   localparam int OFS_CTRL  = 'h00;
   localparam int OFS_DBB   = 'h10;
   localparam int OFS_DBC   = 'h14;
   localparam int OFS_SBB   = 'h18;
   localparam int OFS_SBC   = 'h1C;
   localparam int OFS_ERRA  = 'h20;

   localparam int ENTRY_BYTES = 8;
   localparam int WORD_BYTES  = 4;
endpackage

// File: rtl/ctxl_regs.sv
module ctxl_regs
   import ctxl_pkg::*;
#(
   parameter int AW      = 32,
   parameter int CW      = 16,
   parameter int RAW     = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [RAW-1:0]   cfg_addr,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic             run_end,
   input  logic [EV_N-1:0]  ev_set,
   input  logic             err_valid,
   input  logic [AW-1:0]    err_addr,
   output logic             go,
   output logic             en,
   output logic [AW-1:0]    db_base,
   output logic [CW-1:0]    db_cnt,
   output logic [AW-1:0]    sb_base,
   output logic [CW-1:0]    hp_cnt,
   output logic [CW-1:0]    lp_cnt,
   output logic             irq
);
   logic            en_q, arb_q;
   logic [EV_N-1:0] ie_q, sts_q, w1c;
   logic [AW-1:0]   dbb_q, sbb_q, erra_q;
   logic [CW-1:0]   dbc_q, hpc_q, lpc_q;
   logic            wr_ctrl, irq_raw;
   logic            unused_wdata;

   assign unused_wdata = ^cfg_wdata;
   assign wr_ctrl = cfg_wr && (cfg_addr == RAW'(OFS_CTRL));
   assign go      = wr_ctrl && cfg_wdata[0] && !en_q;
   assign w1c     = wr_ctrl ? cfg_wdata[STS_LSB +: EV_N] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         arb_q  <= 1'b0;
         ie_q   <= '0;
         sts_q  <= '0;
         dbb_q  <= '0;
         sbb_q  <= '0;
         erra_q <= '0;
         dbc_q  <= '0;
         hpc_q  <= '0;
         lpc_q  <= '0;
      end else begin
         if (go)           en_q <= 1'b1;
         else if (run_end) en_q <= 1'b0;
         if (wr_ctrl) begin
            arb_q <= cfg_wdata[1];
            ie_q  <= cfg_wdata[IE_LSB +: EV_N];
         end
         sts_q <= (sts_q & ~w1c) | ev_set;
         if (cfg_wr && cfg_addr == RAW'(OFS_DBB)) dbb_q <= cfg_wdata[AW-1:0];
         if (cfg_wr && cfg_addr == RAW'(OFS_DBC)) dbc_q <= cfg_wdata[CW-1:0];
         if (cfg_wr && cfg_addr == RAW'(OFS_SBB)) sbb_q <= cfg_wdata[AW-1:0];
         if (cfg_wr && cfg_addr == RAW'(OFS_SBC)) begin
            hpc_q <= cfg_wdata[CW-1:0];
            lpc_q <= cfg_wdata[LPC_LSB +: CW];
         end
         if (err_valid) erra_q <= err_addr;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         RAW'(OFS_CTRL): begin
            cfg_rdata[0]                 = en_q;
            cfg_rdata[1]                 = arb_q;
            cfg_rdata[IE_LSB +: EV_N]    = ie_q;
            cfg_rdata[STS_LSB +: EV_N]   = sts_q;
         end
         RAW'(OFS_DBB):  cfg_rdata[AW-1:0] = dbb_q;
         RAW'(OFS_DBC):  cfg_rdata[CW-1:0] = dbc_q;
         RAW'(OFS_SBB):  cfg_rdata[AW-1:0] = sbb_q;
         RAW'(OFS_SBC): begin
            cfg_rdata[CW-1:0]         = hpc_q;
            cfg_rdata[LPC_LSB +: CW]  = lpc_q;
         end
         RAW'(OFS_ERRA): cfg_rdata[AW-1:0] = erra_q;
         default:        cfg_rdata = '0;
      endcase
   end

   assign irq_raw = |(sts_q & ie_q);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

   assign en      = en_q;
   assign db_base = dbb_q;
   assign db_cnt  = dbc_q;
   assign sb_base = sbb_q;
   assign hp_cnt  = hpc_q;
   assign lp_cnt  = lpc_q;

   // R8: a write-one-to-clear removes the read-error flag unless it is set again
   a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && cfg_wdata[STS_LSB + EV_RDERR] && !ev_set[EV_RDERR]) |=> !sts_q[EV_RDERR]);
endmodule

// File: rtl/ctxl_fetch.sv
module ctxl_fetch
   import ctxl_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_rerr,
   input  logic          mem_berr,
   output logic          ent_valid,
   output logic [31:0]   ent_val,
   output logic [31:0]   ent_ofs,
   output ferr_e         err,
   output logic [AW-1:0] err_addr
);
   typedef enum logic [1:0] {F_IDLE, F_VAL, F_OFS} fst_e;

   fst_e          st_q;
   logic [AW-1:0] a_q;
   logic [31:0]   v_q;
   logic          bad;

   assign bad = mem_rerr || mem_berr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= F_IDLE;
         a_q  <= '0;
         v_q  <= '0;
      end else begin
         case (st_q)
            F_IDLE: if (start) begin
               a_q  <= start_addr;
               st_q <= F_VAL;
            end
            F_VAL: if (mem_rvalid) begin
               if (bad) st_q <= F_IDLE;
               else begin
                  v_q  <= mem_rdata;
                  a_q  <= a_q + AW'(WORD_BYTES);
                  st_q <= F_OFS;
               end
            end
            F_OFS: if (mem_rvalid) st_q <= F_IDLE;
            default: st_q <= F_IDLE;
         endcase
      end
   end

   assign mem_req   = (st_q != F_IDLE);
   assign mem_addr  = a_q;
   assign ent_valid = (st_q == F_OFS) && mem_rvalid && !bad;
   assign ent_val   = v_q;
   assign ent_ofs   = mem_rdata;
   assign err_addr  = a_q;

   always_comb begin
      err = FE_NONE;
      if (mem_req && mem_rvalid) begin
         if (mem_rerr)      err = FE_READ;
         else if (mem_berr) err = FE_BUS;
      end
   end

   // R2: an unanswered read keeps its request and address
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/ctxl_seq.sv
module ctxl_seq
   import ctxl_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] db_base,
   input  logic [CW-1:0] db_cnt,
   input  logic [AW-1:0] sb_base,
   input  logic [CW-1:0] hp_cnt,
   input  logic [CW-1:0] lp_cnt,
   output logic          f_start,
   output logic [AW-1:0] f_addr,
   input  logic          f_valid,
   input  logic [31:0]   f_val,
   input  logic [31:0]   f_ofs,
   input  ferr_e         f_err,
   output logic          wr_valid,
   output logic [31:0]   wr_addr,
   output logic [31:0]   wr_data,
   input  logic          wr_ready,
   output logic [2:0]    done_ev,
   output logic          rd_err_ev,
   output logic          bus_err_ev,
   output logic          run_end
);
   typedef enum logic [1:0] {S_IDLE, S_SEL, S_WAIT, S_WRITE} sst_e;

   localparam int SHIFT = $clog2(ENTRY_BYTES);

   sst_e          st_q;
   region_e       rg_q;
   logic [CW-1:0] rem_q, hp_q, lp_q;
   logic [AW-1:0] addr_q, sbb_q, lp_start;
   logic [31:0]   val_q, ofs_q;
   logic          empty;

   assign empty    = (rem_q == '0);
   assign lp_start = sbb_q + (AW'(hp_q) << SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         rg_q   <= RG_DB;
         rem_q  <= '0;
         hp_q   <= '0;
         lp_q   <= '0;
         addr_q <= '0;
         sbb_q  <= '0;
         val_q  <= '0;
         ofs_q  <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (go) begin
               rg_q   <= RG_DB;
               rem_q  <= db_cnt;
               addr_q <= db_base;
               sbb_q  <= sb_base;
               hp_q   <= hp_cnt;
               lp_q   <= lp_cnt;
               st_q   <= S_SEL;
            end
            S_SEL: begin
               if (empty) begin
                  case (rg_q)
                     RG_DB: begin
                        rg_q   <= RG_HP;
                        rem_q  <= hp_q;
                        addr_q <= sbb_q;
                     end
                     RG_HP: begin
                        rg_q   <= RG_LP;
                        rem_q  <= lp_q;
                        addr_q <= lp_start;
                     end
                     default: st_q <= S_IDLE;
                  endcase
               end else begin
                  st_q <= S_WAIT;
               end
            end
            S_WAIT: begin
               if (f_valid) begin
                  val_q <= f_val;
                  ofs_q <= f_ofs;
                  st_q  <= S_WRITE;
               end else if (f_err != FE_NONE) begin
                  st_q <= S_IDLE;
               end
            end
            S_WRITE: if (wr_ready) begin
               rem_q  <= rem_q - CW'(1);
               addr_q <= addr_q + AW'(ENTRY_BYTES);
               st_q   <= S_SEL;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign f_start    = (st_q == S_SEL) && !empty;
   assign f_addr     = addr_q;
   assign wr_valid   = (st_q == S_WRITE);
   assign wr_addr    = ofs_q;
   assign wr_data    = val_q;
   assign rd_err_ev  = (st_q == S_WAIT) && (f_err == FE_READ);
   assign bus_err_ev = (st_q == S_WAIT) && (f_err == FE_BUS);
   assign run_end    = ((st_q == S_SEL) && empty && (rg_q == RG_LP)) ||
                       ((st_q == S_WAIT) && !f_valid && (f_err != FE_NONE));

   always_comb begin
      done_ev = '0;
      if ((st_q == S_WRITE) && wr_ready && (rem_q == CW'(1)))
         done_ev[int'(rg_q)] = 1'b1;
   end

   // R10: a pending register write stays put until accepted
   a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/ctx_loader.sv
module ctx_loader
   import ctxl_pkg::*;
#(
   parameter int AW      = 32,
   parameter int CW      = 16,
   parameter int RAW     = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_wr,
   input  logic [RAW-1:0] cfg_addr,
   input  logic [31:0]    cfg_wdata,
   output logic [31:0]    cfg_rdata,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_rvalid,
   input  logic [31:0]    mem_rdata,
   input  logic           mem_rerr,
   input  logic           mem_berr,
   output logic           wr_valid,
   output logic [31:0]    wr_addr,
   output logic [31:0]    wr_data,
   input  logic           wr_ready,
   input  logic           evt_db_pend,
   input  logic           evt_sb_pend,
   output logic           irq
);
   generate
      if (AW > 32 || AW < 8) begin : g_bad_aw
         $error("ctx_loader: AW must lie in 8..32");
      end
      if (CW > 16 || CW < 1) begin : g_bad_cw
         $error("ctx_loader: CW must lie in 1..16");
      end
      if (RAW < 6) begin : g_bad_raw
         $error("ctx_loader: RAW must reach offset 0x20");
      end
   endgenerate

   logic            go, en, run_end;
   logic [AW-1:0]   db_base, sb_base, f_addr, err_addr;
   logic [CW-1:0]   db_cnt, hp_cnt, lp_cnt;
   logic            f_start, f_valid;
   logic [31:0]     f_val, f_ofs;
   ferr_e           f_err;
   logic [2:0]      done_ev;
   logic            rd_err_ev, bus_err_ev;
   logic [EV_N-1:0] ev_set;

   always_comb begin
      ev_set            = '0;
      ev_set[EV_RDERR]  = rd_err_ev;
      ev_set[EV_DBDONE] = done_ev[0];
      ev_set[EV_HPDONE] = done_ev[1];
      ev_set[EV_LPDONE] = done_ev[2];
      ev_set[EV_DBPEND] = evt_db_pend;
      ev_set[EV_SBPEND] = evt_sb_pend;
      ev_set[EV_BUSERR] = bus_err_ev;
   end

   ctxl_regs #(.AW(AW), .CW(CW), .RAW(RAW), .IRQ_REG(IRQ_REG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .run_end(run_end), .ev_set(ev_set),
      .err_valid(rd_err_ev || bus_err_ev), .err_addr(err_addr),
      .go(go), .en(en),
      .db_base(db_base), .db_cnt(db_cnt), .sb_base(sb_base),
      .hp_cnt(hp_cnt), .lp_cnt(lp_cnt), .irq(irq)
   );

   ctxl_seq #(.AW(AW), .CW(CW)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go),
      .db_base(db_base), .db_cnt(db_cnt), .sb_base(sb_base),
      .hp_cnt(hp_cnt), .lp_cnt(lp_cnt),
      .f_start(f_start), .f_addr(f_addr), .f_valid(f_valid),
      .f_val(f_val), .f_ofs(f_ofs), .f_err(f_err),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .done_ev(done_ev), .rd_err_ev(rd_err_ev), .bus_err_ev(bus_err_ev),
      .run_end(run_end)
   );

   ctxl_fetch #(.AW(AW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(f_start), .start_addr(f_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .mem_berr(mem_berr),
      .ent_valid(f_valid), .ent_val(f_val), .ent_ofs(f_ofs),
      .err(f_err), .err_addr(err_addr)
   );

   // R1: no memory or register traffic outside a run
   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!mem_req && !wr_valid));

   // R6: an error response stops all traffic in the next cycle
   a_r6_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_err_ev || bus_err_ev) |=> (!wr_valid && !mem_req && !en));
endmodule

// File: tb/ctx_loader_tb.sv
`timescale 1ns/1ps
module ctx_loader_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_rerr = 1'b0;
   logic        mem_berr = 1'b0;
   logic        wr_valid;
   logic [31:0] wr_addr, wr_data;
   logic        wr_ready = 1'b0;
   logic        evt_db_pend = 1'b0;
   logic        evt_sb_pend = 1'b0;
   logic        irq;

   always #4 clk = ~clk;

   ctx_loader u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .mem_berr(mem_berr),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .evt_db_pend(evt_db_pend), .evt_sb_pend(evt_sb_pend), .irq(irq)
   );

   localparam logic [7:0] A_CTRL = 8'h00, A_DBB = 8'h10, A_DBC = 8'h14,
                          A_SBB = 8'h18, A_SBC = 8'h1C, A_ERRA = 8'h20;

   int n_chk = 0, n_fail = 0;
   logic [31:0] mem [0:1023];
   logic [31:0] log_a [0:63];
   logic [31:0] log_d [0:63];
   int log_n = 0;
   int lat_cnt = 0;
   bit slow = 0;
   bit err_on = 0, err_bus = 0;
   logic [31:0] err_at = '0;
   int cur_db, cur_hp, cur_lp, cur_dbb, cur_sbb;

   // memory responder and write sink, both driven away from the sampling edge
   always @(negedge clk) begin
      wr_ready = slow ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 3) != 0);
      if (wr_valid && wr_ready && log_n < 64) begin
         log_a[log_n] = wr_addr;
         log_d[log_n] = wr_data;
         log_n++;
      end
      if (mem_rvalid) begin
         mem_rvalid = 1'b0;
         mem_rerr   = 1'b0;
         mem_berr   = 1'b0;
      end else if (mem_req) begin
         if (lat_cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[mem_addr[11:2]];
            if (err_on && mem_addr == err_at) begin
               if (err_bus) mem_berr = 1'b1;
               else         mem_rerr = 1'b1;
            end
            lat_cnt = $urandom_range(0, 2);
         end else begin
            lat_cnt--;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] v;
      int k;
      v = 32'h1;
      for (k = 0; k < 20000 && v[0]; k++) cfg_read(A_CTRL, v);
      if (v[0]) chk({tag, " run end"}, v & 32'h1, 32'h0);
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [31:0] ent_word(input int i, input int w);
      int base, k;
      if (i < cur_db) begin base = cur_dbb; k = i; end
      else begin base = cur_sbb; k = i - cur_db; end
      return mem[(base >> 2) + 2 * k + w];
   endfunction

   function automatic logic [31:0] exp_sts(input int db, input int hp, input int lp);
      return ((db != 0) ? 32'h0002_0000 : 32'h0) | ((hp != 0) ? 32'h0004_0000 : 32'h0) |
             ((lp != 0) ? 32'h0008_0000 : 32'h0);
   endfunction

   task automatic start_run(input int dbb, input int db, input int sbb, input int hp,
                            input int lp, input logic [6:0] ie);
      cur_dbb = dbb; cur_db = db; cur_sbb = sbb; cur_hp = hp; cur_lp = lp;
      cfg_write(A_DBB, dbb);
      cfg_write(A_DBC, db);
      cfg_write(A_SBB, sbb);
      cfg_write(A_SBC, (lp << 16) | hp);
      log_n = 0;
      cfg_write(A_CTRL, 32'h1 | (32'(ie) << 2));
   endtask

   task automatic check_log(input string tag, input int n_exp);
      chk({tag, " write count"}, log_n, n_exp);
      for (int i = 0; i < n_exp && i < log_n; i++) begin
         chk({tag, " offset"}, log_a[i], ent_word(i, 1));
         chk({tag, " value"},  log_d[i], ent_word(i, 0));
      end
   endtask

   task automatic status_is(input string tag, input logic [31:0] exp);
      logic [31:0] v;
      cfg_read(A_CTRL, v);
      chk(tag, v & 32'h007F_0001, exp);
   endtask

   task automatic clear_all();
      cfg_write(A_CTRL, 32'h007F_0000);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      int db, hp, lp, dbb, sbb;
      v = $urandom(32'd5150);
      for (int i = 0; i < 1024; i++) mem[i] = $urandom;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      chk("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);
      rst_n = 1'b1;
      cfg_read(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
      cfg_read(A_DBB, v);  chk("R1 db base reset", v, 32'h0);
      cfg_read(A_SBC, v);  chk("R1 sb count reset", v, 32'h0);
      cfg_read(A_ERRA, v); chk("R1 error address reset", v, 32'h0);

      // R2 R3 R5: all three regions populated, interrupts masked
      start_run(32'h100, 3, 32'h400, 2, 2, 7'h00);
      cfg_read(A_CTRL, v); chk("R5 enable reads 1 during run", v & 32'h1, 32'h1);
      wait_idle("R3");
      check_log("R2 R3 full order", 7);
      status_is("R5 completion flags", exp_sts(3, 2, 2));
      chk("R9 masked flags keep irq low", {31'b0, irq}, 32'h0);

      // R8: write-one-to-clear on one flag only
      cfg_write(A_CTRL, 32'h0002_0000);
      status_is("R8 clear one flag", 32'h000C_0000);
      clear_all();
      status_is("R8 clear all", 32'h0);

      // R4 R3: only the low-priority sublist, starting at the region base
      start_run(32'h100, 0, 32'h480, 0, 3, 7'h00);
      wait_idle("R4");
      check_log("R4 R3 low-priority only", 3);
      status_is("R4 only low-priority flag", 32'h0008_0000);
      clear_all();

      // R4: every region empty
      start_run(32'h100, 0, 32'h400, 0, 0, 7'h00);
      wait_idle("R4 empty");
      chk("R4 no writes for empty run", log_n, 0);
      status_is("R4 empty run flags", 32'h0);

      // R9: enabled completion raises irq, clearing lowers it
      start_run(32'h180, 1, 32'h400, 0, 0, 7'h7F);
      wait_idle("R9");
      chk("R9 irq on enabled flag", {31'b0, irq}, 32'h1);
      cfg_write(A_CTRL, 32'h007F_0000 | (32'h7F << 2));
      repeat (2) @(negedge clk);
      chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
      clear_all();

      // R6: read error on the offset word of the second double-buffered entry
      err_on = 1; err_bus = 0; err_at = 32'h10C;
      start_run(32'h100, 2, 32'h400, 1, 0, 7'h00);
      wait_idle("R6 read");
      check_log("R6 entries before read error", 1);
      status_is("R6 read error flag", 32'h0001_0000);
      cfg_read(A_ERRA, v); chk("R6 read error address", v, 32'h10C);
      clear_all();

      // R6: bus error on the very first single-buffered read
      err_bus = 1; err_at = 32'h400;
      start_run(32'h100, 0, 32'h400, 2, 0, 7'h00);
      wait_idle("R6 bus");
      chk("R6 no writes after bus error", log_n, 0);
      status_is("R6 bus error flag", 32'h0040_0000);
      cfg_read(A_ERRA, v); chk("R6 bus error address", v, 32'h400);
      err_on = 0;
      clear_all();

      // R7: re-arm and count rewrite during a slow run
      slow = 1;
      start_run(32'h200, 6, 32'h400, 0, 0, 7'h00);
      cfg_write(A_DBC, 32'd2);
      cfg_write(A_CTRL, 32'h1);
      cfg_read(A_CTRL, v); chk("R7 still running", v & 32'h1, 32'h1);
      wait_idle("R7");
      check_log("R7 sampled count used", 6);
      cfg_read(A_DBC, v); chk("R7 rewritten count stored", v, 32'd2);
      slow = 0;
      log_n = 0;
      cur_db = 2;
      cfg_write(A_CTRL, 32'h1);
      wait_idle("R7 next");
      check_log("R7 next run uses new count", 2);
      clear_all();

      // R8 R9: external events and their mask
      cfg_write(A_CTRL, 32'h1 << (2 + 4));
      @(negedge clk); evt_sb_pend = 1'b1; @(negedge clk); evt_sb_pend = 1'b0;
      status_is("R8 sb pending event flag", 32'h0020_0000);
      repeat (2) @(negedge clk);
      chk("R9 masked event keeps irq low", {31'b0, irq}, 32'h0);
      @(negedge clk); evt_db_pend = 1'b1; @(negedge clk); evt_db_pend = 1'b0;
      status_is("R8 db pending event flag", 32'h0030_0000);
      repeat (2) @(negedge clk);
      chk("R9 enabled event raises irq", {31'b0, irq}, 32'h1);
      clear_all();

      // R2 R3 R5: random lists
      for (int r = 0; r < 20; r++) begin
         db = $urandom_range(0, 5); hp = $urandom_range(0, 5); lp = $urandom_range(0, 5);
         dbb = 8 * $urandom_range(0, 90);
         sbb = 32'h400 + 8 * $urandom_range(0, 300);
         for (int i = 0; i < 2 * db; i++) mem[(dbb >> 2) + i] = $urandom;
         for (int i = 0; i < 2 * (hp + lp); i++) mem[(sbb >> 2) + i] = $urandom;
         start_run(dbb, db, sbb, hp, lp, 7'h00);
         wait_idle("R3 random");
         check_log("R2 R3 random run", db + hp + lp);
         status_is("R5 random flags", exp_sts(db, hp, lp));
         clear_all();
      end

      summary();
      $finish;
   end
endmodule